// File: doc/BRIEF.md
# Instruction Packet Commit Controller

This block gathers every side effect produced while one very-long-instruction-word packet executes and applies them together when the packet ends. During the collect phase it logs register writes into a shadow array, merges predicate writes, keeps the first taken branch and holds up to two pending stores, one per store slot. A per-slot cancel input can kill a store before it commits. When the packet ends, a single write-back cycle moves the shadow registers, merged predicates and next program counter into their architectural copies. The surviving stores then drain through a valid/ready memory port, slot 0 first.

There is one ordering rule inside the packet. A load issued from slot 0 may not read memory while slot 1 still holds a live store. The controller grants such a load only after it has pushed that store out early, and the store is not repeated at packet end. The surrounding pipeline pulses `pkt_start` before each packet and `pkt_end` after its last log cycle. It waits for `pkt_done` before starting the next packet.

The controller is a six-state machine. COLLECT accepts logs. EARLY drains the slot-1 store for a blocked slot-0 load. WRITEBACK makes the commit. STORE0 and STORE1 drain the stores. DONE signals the end of the commit. The transitions are:
- COLLECT→WRITEBACK on `pkt_end`.
- COLLECT→EARLY on a blocked slot-0 load.
- EARLY→COLLECT on `mem_ready`.
- WRITEBACK→STORE0, STORE1 or DONE, depending on which stores are live.
- STORE0→STORE1 or DONE on `mem_ready`.
- STORE1→DONE on `mem_ready`.
- DONE→COLLECT unconditionally.

Top module: `pkt_commit_ctrl`

## Requirements
- R1: After reset, `next_pc`, `pred_out`, every architectural register, `mem_valid`, `ld_go`, `pkt_done`, `pc_misalign` and `size_err` are all zero.
- R2: A predicate written more than once in a packet commits the bitwise AND of all its values. A predicate written once commits that value. An unwritten predicate keeps its old value. Predicate i occupies `pred_out[8*i+7:8*i]`, and `pred_out` changes only in the write-back cycle.
- R3: `next_pc` takes the target of the first branch logged in the packet and ignores later ones. With no branch, it takes the `seq_pc` sampled with `pkt_end`.
- R4: `pc_misalign` is set when the accepted branch target has any of its low `ALIGN_BITS` (2) bits set. Targets of ignored later branches do not affect it.
- R5: Register writes are invisible on `rd_data` until write-back. After write-back, each written register holds the last value logged for it.
- R6: A store whose size is not 1, 2, 4 or 8 bytes is dropped and sets `size_err` for the packet. `mem_size` carries the size in bytes.
- R7: A store in a slot whose bit is set in `cancel_set` (bit s for slot s) is never issued.
- R8: At packet end, the live slot-0 store is issued before the live slot-1 store.
- R9: A slot-0 load (`ld_slot`=0) with a live slot-1 store holds `ld_go` low until that store has been accepted by memory. The store is not issued again at packet end.
- R10: A slot-1 load, or a slot-0 load with no live slot-1 store, sees `ld_go` high in the same cycle as the request.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_size` and `mem_data` hold their values.
- R12: `pkt_start` clears the branch-taken state, the predicate written marks, the cancel marks, the logged stores and both error flags.
- R13: `pkt_done` is high for exactly one cycle per commit, after the last store has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | Clears per-packet state (COLLECT only) |
| pkt_end | input | 1 | Ends the packet and starts the commit |
| seq_pc | input | AW | Fall-through address, sampled with pkt_end |
| reg_we | input | 1 | Register write log enable |
| reg_idx | input | log2(NREG) | Register index |
| reg_data | input | DW | Register write value |
| rd_idx | input | log2(NREG) | Architectural register read index |
| rd_data | output | DW | Architectural register read data |
| pred_we | input | 1 | Predicate write log enable |
| pred_idx | input | log2(NPRED) | Predicate index |
| pred_val | input | PW | Predicate write value |
| pred_out | output | NPRED*PW | Architectural predicates |
| br_valid | input | 1 | Taken branch log |
| br_target | input | AW | Branch target |
| cancel_set | input | 2 | Per-slot cancel request |
| st_we | input | 1 | Store log enable |
| st_slot | input | 1 | Store slot |
| st_addr | input | AW | Store address |
| st_size | input | 4 | Store size in bytes |
| st_data | input | SDW | Store data |
| ld_req | input | 1 | Load wants to read memory |
| ld_slot | input | 1 | Slot of the load |
| ld_go | output | 1 | Load may read memory |
| mem_valid | output | 1 | Store request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Store address |
| mem_size | output | 4 | Store size in bytes |
| mem_data | output | SDW | Store data |
| next_pc | output | AW | Committed next program counter |
| pc_misalign | output | 1 | Accepted branch target misaligned |
| size_err | output | 1 | Illegal store size logged this packet |
| pkt_done | output | 1 | Commit finished |

## Verification
Directed packets write the same predicate twice and once, and leave others untouched. This separates the AND merge from last-write-wins and from a stale written mark after a new `pkt_start`. Packets with two branches, a misaligned first target and no branch tell first-wins apart from last-wins and from the fall-through path. Store packets with both slots live, one slot cancelled, an illegal size and a stalled memory expose ordering, cancellation and handshake-hold faults. Slot-0 and slot-1 loads, with a live, cancelled or absent slot-1 store, show whether the early drain fires only when it must. Seeded random packets mix all of these kinds of traffic against a bench model.

// File: rtl/pkt_commit_pkg.sv
package pkt_commit_pkg;
    localparam int NSLOT = 2;
    localparam int SZW   = 4;

    typedef enum logic [2:0] {
        S_COLLECT,
        S_EARLY,
        S_WB,
        S_ST0,
        S_ST1,
        S_DONE
    } pcc_state_e;

    function automatic logic size_legal(input logic [SZW-1:0] sz);
        return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
    endfunction
endpackage

// File: rtl/pcc_pred_merge.sv
module pcc_pred_merge #(
    parameter int NPRED = 4,
    parameter int PW    = 8,
    localparam int PIW  = $clog2(NPRED)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                we,
    input  logic [PIW-1:0]      idx,
    input  logic [PW-1:0]       val,
    input  logic                commit,
    output logic [NPRED*PW-1:0] arch
);
    for (genvar g = 0; g < NPRED; g++) begin : g_pred
        logic          wr_q;
        logic [PW-1:0] sh_q;
        logic [PW-1:0] ar_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wr_q <= 1'b0;
                sh_q <= '0;
                ar_q <= '0;
            end else begin
                if (clr) begin
                    wr_q <= 1'b0;
                end else if (we && idx == PIW'(g)) begin
                    // repeated writes in one packet merge by AND
                    sh_q <= wr_q ? (sh_q & val) : val;
                    wr_q <= 1'b1;
                end
                if (commit && wr_q) ar_q <= sh_q;
            end
        end
        assign arch[g*PW +: PW] = ar_q;
    end
endmodule

// File: rtl/pcc_reg_shadow.sv
module pcc_reg_shadow #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    localparam int RIW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           we,
    input  logic [RIW-1:0] idx,
    input  logic [DW-1:0]  data,
    input  logic           commit,
    input  logic [RIW-1:0] rd_idx,
    output logic [DW-1:0]  rd_data
);
    logic [NREG-1:0][DW-1:0] arch_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic          wr_q;
        logic [DW-1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wr_q      <= 1'b0;
                sh_q      <= '0;
                arch_q[g] <= '0;
            end else begin
                if (clr) begin
                    wr_q <= 1'b0;
                end else if (we && idx == RIW'(g)) begin
                    sh_q <= data;
                    wr_q <= 1'b1;
                end
                if (commit && wr_q) arch_q[g] <= sh_q;
            end
        end
    end

    assign rd_data = arch_q[rd_idx];
endmodule

// File: rtl/pcc_store_slots.sv
module pcc_store_slots
    import pkt_commit_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SDW = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            log_we,
    input  logic                            log_slot,
    input  logic [AW-1:0]                   log_addr,
    input  logic [SZW-1:0]                  log_size,
    input  logic [SDW-1:0]                  log_data,
    input  logic [NSLOT-1:0]                cancel_set,
    input  logic [NSLOT-1:0]                done_set,
    output logic [NSLOT-1:0]                live,
    output logic [NSLOT-1:0][AW-1:0]        slot_addr,
    output logic [NSLOT-1:0][SZW-1:0]       slot_size,
    output logic [NSLOT-1:0][SDW-1:0]       slot_data
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic vld_q, cnl_q, done_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q        <= 1'b0;
                cnl_q        <= 1'b0;
                done_q       <= 1'b0;
                slot_addr[g] <= '0;
                slot_size[g] <= '0;
                slot_data[g] <= '0;
            end else if (clr) begin
                vld_q  <= 1'b0;
                cnl_q  <= 1'b0;
                done_q <= 1'b0;
            end else begin
                if (log_we && log_slot == 1'(g)) begin
                    vld_q        <= 1'b1;
                    slot_addr[g] <= log_addr;
                    slot_size[g] <= log_size;
                    slot_data[g] <= log_data;
                end
                if (cancel_set[g]) cnl_q  <= 1'b1;
                if (done_set[g])   done_q <= 1'b1;
            end
        end
        assign live[g] = vld_q & ~cnl_q & ~done_q;
    end
endmodule

// File: rtl/pkt_commit_ctrl.sv
module pkt_commit_ctrl
    import pkt_commit_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int NREG       = 8,
    parameter int NPRED      = 4,
    parameter int PW         = 8,
    parameter int SDW        = 64,
    parameter int ALIGN_BITS = 2,
    localparam int RIW       = $clog2(NREG),
    localparam int PIW       = $clog2(NPRED)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pkt_start,
    input  logic                pkt_end,
    input  logic [AW-1:0]       seq_pc,
    input  logic                reg_we,
    input  logic [RIW-1:0]      reg_idx,
    input  logic [DW-1:0]       reg_data,
    input  logic [RIW-1:0]      rd_idx,
    output logic [DW-1:0]       rd_data,
    input  logic                pred_we,
    input  logic [PIW-1:0]      pred_idx,
    input  logic [PW-1:0]       pred_val,
    output logic [NPRED*PW-1:0] pred_out,
    input  logic                br_valid,
    input  logic [AW-1:0]       br_target,
    input  logic [NSLOT-1:0]    cancel_set,
    input  logic                st_we,
    input  logic                st_slot,
    input  logic [AW-1:0]       st_addr,
    input  logic [SZW-1:0]      st_size,
    input  logic [SDW-1:0]      st_data,
    input  logic                ld_req,
    input  logic                ld_slot,
    output logic                ld_go,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [AW-1:0]       mem_addr,
    output logic [SZW-1:0]      mem_size,
    output logic [SDW-1:0]      mem_data,
    output logic [AW-1:0]       next_pc,
    output logic                pc_misalign,
    output logic                size_err,
    output logic                pkt_done
);
    pcc_state_e state, nxt;

    logic                       collect, clr, accept, commit, sel, early_need;
    logic [NSLOT-1:0]           live, done_set;
    logic [NSLOT-1:0][AW-1:0]   slot_addr;
    logic [NSLOT-1:0][SZW-1:0]  slot_size;
    logic [NSLOT-1:0][SDW-1:0]  slot_data;
    logic                       br_taken_q;
    logic [AW-1:0]              tgt_q, seq_q;

    assign collect    = (state == S_COLLECT);
    assign clr        = collect && pkt_start;
    assign accept     = collect && !pkt_start;
    assign early_need = accept && !pkt_end && ld_req && !ld_slot && live[1];
    assign ld_go      = accept && !pkt_end && ld_req && !(!ld_slot && live[1]);

    pcc_reg_shadow #(.NREG(NREG), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(clr), .we(accept && reg_we),
        .idx(reg_idx), .data(reg_data), .commit(commit),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    pcc_pred_merge #(.NPRED(NPRED), .PW(PW)) u_preds (
        .clk(clk), .rst_n(rst_n), .clr(clr), .we(accept && pred_we),
        .idx(pred_idx), .val(pred_val), .commit(commit), .arch(pred_out)
    );

    pcc_store_slots #(.AW(AW), .SDW(SDW)) u_stores (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .log_we(accept && st_we && size_legal(st_size)),
        .log_slot(st_slot), .log_addr(st_addr), .log_size(st_size),
        .log_data(st_data),
        .cancel_set(accept ? cancel_set : '0), .done_set(done_set),
        .live(live), .slot_addr(slot_addr), .slot_size(slot_size),
        .slot_data(slot_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_COLLECT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_COLLECT: begin
                if (accept && pkt_end) nxt = S_WB;
                else if (early_need)   nxt = S_EARLY;
            end
            S_EARLY: if (mem_ready) nxt = S_COLLECT;
            S_WB:    nxt = live[0] ? S_ST0 : (live[1] ? S_ST1 : S_DONE);
            S_ST0:   if (mem_ready) nxt = live[1] ? S_ST1 : S_DONE;
            S_ST1:   if (mem_ready) nxt = S_DONE;
            S_DONE:  nxt = S_COLLECT;
            default: nxt = S_COLLECT;
        endcase
    end

    // outputs
    always_comb begin
        mem_valid = 1'b0;
        sel       = 1'b0;
        commit    = 1'b0;
        pkt_done  = 1'b0;
        done_set  = '0;
        unique case (state)
            S_EARLY: begin mem_valid = 1'b1; sel = 1'b1; done_set[1] = mem_ready; end
            S_WB:    commit = 1'b1;
            S_ST0:   begin mem_valid = 1'b1; done_set[0] = mem_ready; end
            S_ST1:   begin mem_valid = 1'b1; sel = 1'b1; done_set[1] = mem_ready; end
            S_DONE:  pkt_done = 1'b1;
            default: ;
        endcase
        mem_addr = slot_addr[sel];
        mem_size = slot_size[sel];
        mem_data = slot_data[sel];
    end

    // per-packet branch, error and pc state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            br_taken_q  <= 1'b0;
            tgt_q       <= '0;
            seq_q       <= '0;
            next_pc     <= '0;
            pc_misalign <= 1'b0;
            size_err    <= 1'b0;
        end else begin
            if (clr) begin
                br_taken_q  <= 1'b0;
                pc_misalign <= 1'b0;
                size_err    <= 1'b0;
            end else if (accept) begin
                if (br_valid && !br_taken_q) begin
                    br_taken_q  <= 1'b1;
                    tgt_q       <= br_target;
                    pc_misalign <= |br_target[ALIGN_BITS-1:0];
                end
                if (st_we && !size_legal(st_size)) size_err <= 1'b1;
                if (pkt_end) seq_q <= seq_pc;
            end
            if (commit) next_pc <= br_taken_q ? tgt_q : seq_q;
        end
    end
endmodule

// File: rtl/pkt_commit_chk.sv
module pkt_commit_chk #(
    parameter int AW  = 32,
    parameter int SDW = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_valid,
    input logic           mem_ready,
    input logic [AW-1:0]  mem_addr,
    input logic [3:0]     mem_size,
    input logic [SDW-1:0] mem_data,
    input logic           ld_go,
    input logic           pkt_done
);
    a_r11_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid);

    a_r11_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> $stable(mem_addr) && $stable(mem_size) && $stable(mem_data));

    a_r6_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_size) == 1));

    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    a_r9_go_not_during_store: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |-> !mem_valid);
endmodule

bind pkt_commit_ctrl pkt_commit_chk #(.AW(AW), .SDW(SDW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_data(mem_data),
    .ld_go(ld_go), .pkt_done(pkt_done)
);

// File: tb/pkt_commit_ctrl_bench.sv
module pkt_commit_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        pkt_start = 0, pkt_end = 0;
    logic [31:0] seq_pc = 0;
    logic        reg_we = 0;
    logic [2:0]  reg_idx = 0, rd_idx = 0;
    logic [31:0] reg_data = 0, rd_data;
    logic        pred_we = 0;
    logic [1:0]  pred_idx = 0;
    logic [7:0]  pred_val = 0;
    logic [31:0] pred_out;
    logic        br_valid = 0;
    logic [31:0] br_target = 0;
    logic [1:0]  cancel_set = 0;
    logic        st_we = 0, st_slot = 0;
    logic [31:0] st_addr = 0;
    logic [3:0]  st_size = 0;
    logic [63:0] st_data = 0;
    logic        ld_req = 0, ld_slot = 0, ld_go;
    logic        mem_valid, mem_ready = 0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_size;
    logic [63:0] mem_data;
    logic [31:0] next_pc;
    logic        pc_misalign, size_err, pkt_done;

    pkt_commit_ctrl u_pkt_commit_ctrl (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    int rec_n = 0;
    logic [31:0] rec_addr [8];
    logic [3:0]  rec_size [8];
    logic [63:0] rec_data [8];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic step; @(negedge clk); endtask

    task automatic start_pkt; pkt_start = 1; step; pkt_start = 0; endtask
    task automatic log_pred(input int i, input logic [7:0] v);
        pred_we = 1; pred_idx = 2'(i); pred_val = v; step; pred_we = 0;
    endtask
    task automatic log_reg(input int i, input logic [31:0] v);
        reg_we = 1; reg_idx = 3'(i); reg_data = v; step; reg_we = 0;
    endtask
    task automatic log_br(input logic [31:0] t);
        br_valid = 1; br_target = t; step; br_valid = 0;
    endtask
    task automatic log_st(input int s, input logic [31:0] a, input logic [3:0] z, input logic [63:0] d);
        st_we = 1; st_slot = 1'(s); st_addr = a; st_size = z; st_data = d; step; st_we = 0;
    endtask
    task automatic log_cancel(input logic [1:0] m);
        cancel_set = m; step; cancel_set = 0;
    endtask

    // ends the packet and serves the memory port until pkt_done
    task automatic commit(input logic [31:0] sp, input int stall);
        logic [31:0] a0;
        int st_left, seen;
        st_left = stall; seen = 0;
        pkt_end = 1; seq_pc = sp; step; pkt_end = 0;
        for (int k = 0; k < 100; k++) begin
            #1;
            if (pkt_done) begin seen = 1; break; end
            if (mem_valid) begin
                if (st_left > 0) begin
                    if (st_left == stall) a0 = mem_addr;
                    else check("R11 hold during stall", {32'h0, mem_addr}, {32'h0, a0});
                    st_left--;
                    mem_ready = 0;
                end else begin
                    mem_ready = 1'($urandom % 2);
                    if (mem_ready) begin
                        rec_addr[rec_n] = mem_addr; rec_size[rec_n] = mem_size;
                        rec_data[rec_n] = mem_data; rec_n++;
                    end
                end
            end
            step; mem_ready = 0;
        end
        check("R13 pkt_done seen", 64'(seen), 64'd1);
        step; #1;
        check("R13 pkt_done single cycle", 64'(pkt_done), 64'd0);
    endtask

    // requests a load; returns stores seen before ld_go
    task automatic do_load(input int s, output int early);
        int n0;
        n0 = rec_n;
        ld_req = 1; ld_slot = 1'(s);
        for (int k = 0; k < 50; k++) begin
            #1;
            if (ld_go) break;
            if (mem_valid) begin
                mem_ready = 1;
                rec_addr[rec_n] = mem_addr; rec_size[rec_n] = mem_size;
                rec_data[rec_n] = mem_data; rec_n++;
            end
            step; mem_ready = 0;
        end
        check("R9/R10 ld_go granted", 64'(ld_go), 64'd1);
        early = rec_n - n0;
        step; ld_req = 0;
    endtask

    function automatic logic [31:0] pack_preds(input logic [7:0] p [4]);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = p[i];
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report;
        $finish;
    end

    initial begin
        logic [7:0]  ep [4];
        logic [7:0]  sh [4];
        logic [3:0]  wr;
        logic [31:0] e_addr [2];
        logic [3:0]  e_size [2];
        logic [63:0] e_data [2];
        int          e_n, early;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) ep[i] = 0;

        repeat (3) step;
        rst_n = 1; step; #1;
        // R1 reset state
        check("R1 next_pc", 64'(next_pc), 0);
        check("R1 pred_out", 64'(pred_out), 0);
        check("R1 mem_valid/pkt_done/ld_go", {61'h0, mem_valid, pkt_done, ld_go}, 0);
        check("R1 rd_data", 64'(rd_data), 0);
        check("R1 flags", {62'h0, pc_misalign, size_err}, 0);

        // R2 R3 R5 directed
        start_pkt;
        log_pred(1, 8'hF3); log_pred(1, 8'h3C); log_pred(2, 8'hAA);
        log_reg(3, 32'hDEADBEEF); log_reg(3, 32'h12345678);
        log_br(32'h100); log_br(32'h204);
        rd_idx = 3; #1;
        check("R5 shadow hidden before commit", 64'(rd_data), 0);
        check("R2 preds unchanged before commit", 64'(pred_out), 0);
        commit(32'h40, 0);
        ep[1] = 8'h30; ep[2] = 8'hAA;
        check("R2 AND merge", 64'(pred_out), 64'(pack_preds(ep)));
        check("R5 last write committed", 64'(rd_data), 64'h12345678);
        check("R3 first branch wins", 64'(next_pc), 64'h100);
        check("R4 aligned target", 64'(pc_misalign), 0);

        // R12 cleared marks, R3 fall-through
        start_pkt;
        log_pred(1, 8'h0F);
        commit(32'h80, 0);
        ep[1] = 8'h0F;
        check("R12 pred mark cleared", 64'(pred_out), 64'(pack_preds(ep)));
        check("R12/R3 no branch uses seq_pc", 64'(next_pc), 64'h80);

        // R4 misaligned first target, aligned second ignored
        start_pkt;
        log_br(32'h102); log_br(32'h200);
        commit(32'h0, 0);
        check("R4 misalign flag", 64'(pc_misalign), 1);
        check("R4 target kept", 64'(next_pc), 64'h102);
        start_pkt; #1;
        check("R12 misalign cleared", 64'(pc_misalign), 0);

        // R8 R11 order with stall
        rec_n = 0;
        log_st(1, 32'hA100, 4'd4, 64'h1111);
        log_st(0, 32'hA000, 4'd8, 64'h0123456789ABCDEF);
        commit(32'h0, 3);
        check("R8 two stores", 64'(rec_n), 2);
        check("R8 slot0 first", 64'(rec_addr[0]), 64'hA000);
        check("R8 slot0 data", rec_data[0], 64'h0123456789ABCDEF);
        check("R8 slot1 second", 64'(rec_addr[1]), 64'hA100);
        check("R6 size carried", 64'(rec_size[1]), 4);

        // R7 cancel slot 0
        start_pkt; rec_n = 0;
        log_st(0, 32'hB000, 4'd2, 64'h5); log_st(1, 32'hB100, 4'd1, 64'h6);
        log_cancel(2'b01);
        commit(32'h0, 0);
        check("R7 one store", 64'(rec_n), 1);
        check("R7 survivor", 64'(rec_addr[0]), 64'hB100);

        // R6 illegal size
        start_pkt; rec_n = 0;
        log_st(0, 32'hC000, 4'd3, 64'h7); log_st(1, 32'hC100, 4'd2, 64'h8);
        commit(32'h0, 0);
        check("R6 size_err", 64'(size_err), 1);
        check("R6 dropped", 64'(rec_n), 1);
        check("R6 legal kept", 64'(rec_addr[0]), 64'hC100);

        // R9 early slot-1 drain
        start_pkt; rec_n = 0;
        log_st(1, 32'hD100, 4'd4, 64'h9); log_st(0, 32'hD000, 4'd4, 64'hA);
        do_load(0, early);
        check("R9 early store count", 64'(early), 1);
        check("R9 early store is slot1", 64'(rec_addr[0]), 64'hD100);
        commit(32'h0, 0);
        check("R9 no repeat", 64'(rec_n), 2);
        check("R9 slot0 at end", 64'(rec_addr[1]), 64'hD000);

        // R10 slot-1 load and cancelled slot-1 store
        start_pkt; rec_n = 0;
        log_st(1, 32'hE100, 4'd4, 64'hB);
        do_load(1, early);
        check("R10 slot1 load immediate", 64'(early), 0);
        log_cancel(2'b10);
        do_load(0, early);
        check("R10 cancelled store no drain", 64'(early), 0);
        commit(32'h0, 0);
        check("R7 cancelled store never issued", 64'(rec_n), 0);

        // random packets
        for (int p = 0; p < 40; p++) begin
            logic [31:0] sp, first;
            int nw, nb;
            start_pkt; rec_n = 0; wr = 0;
            nw = $urandom % 5;
            for (int w = 0; w < nw; w++) begin
                int i; logic [7:0] v;
                i = $urandom % 4; v = 8'($urandom);
                sh[i] = wr[i] ? (sh[i] & v) : v; wr[i] = 1;
                log_pred(i, v);
            end
            sp = ($urandom & 32'hFFFC);
            nb = $urandom % 3; first = sp;
            for (int b = 0; b < nb; b++) begin
                logic [31:0] t;
                t = $urandom & 32'hFFFC;
                if (b == 0) first = t;
                log_br(t);
            end
            e_n = 0;
            for (int s = 0; s < 2; s++) begin
                if ($urandom % 2 == 1) begin
                    logic [31:0] a; logic [3:0] z; logic [63:0] d;
                    a = $urandom; z = 4'(1 << ($urandom % 4)); d = {$urandom, $urandom};
                    log_st(s, a, z, d);
                    if ($urandom % 4 == 0) log_cancel(2'(1 << s));
                    else begin e_addr[e_n] = a; e_size[e_n] = z; e_data[e_n] = d; e_n++; end
                end
            end
            commit(sp, $urandom % 2);
            for (int i = 0; i < 4; i++) if (wr[i]) ep[i] = sh[i];
            check("R2 random preds", 64'(pred_out), 64'(pack_preds(ep)));
            check("R3 random next_pc", 64'(next_pc), 64'(first));
            check("R8 random store count", 64'(rec_n), 64'(e_n));
            for (int k = 0; k < e_n && k < rec_n; k++) begin
                check("R8 random addr", 64'(rec_addr[k]), 64'(e_addr[k]));
                check("R6 random size", 64'(rec_size[k]), 64'(e_size[k]));
                check("R8 random data", rec_data[k], e_data[k]);
            end
        end

        report;
        $finish;
    end
endmodule